// File: doc/BRIEF.md
# Receive Character Queue with Trigger Level and Idle Timeout

This block is the receive-side buffer of a serial port. A deserializer hands it one character at a time, together with three error flags (parity, framing, line break). The block keeps up to 16 such entries in arrival order. It shows the oldest entry to a reader, and it raises two interrupt requests. The first fires when the number of stored characters reaches a programmable threshold. The second fires when characters have been left waiting for several character times. It also reports whether any stored entry carries an error, and it signals an overrun when a character arrives with no room left for it.

Software controls the block with a single control byte. One bit turns queueing on or off. Two bits each flush a queue: the receive queue held here, or the transmit queue kept elsewhere, which this block tells to flush through a one-cycle pulse. Two further bits choose the threshold. While queueing is off, the block holds a single character, as a plain holding register would.

Top module: `rx_queue_ctrl`

## Requirements
- R1: After reset, `data_ready`, `err_any`, `trig_irq`, `timeout_irq`, `overrun`, `tx_flush` and `fifo_on` are all 0. The threshold code is 00.
- R2: Entries leave in arrival order. The head outputs show the oldest entry's character and flags whenever `data_ready` is 1, and `data_ready` is 1 exactly when at least one entry is stored. A pop takes effect at the clock edge where `rd_pop` is high. A pop while empty is ignored.
- R3: With queueing on, the block holds up to DEPTH (16) entries. With queueing off, it holds one.
- R4: A character that arrives when the queue is full is discarded and the stored entries are unchanged. `overrun` is then 1 for the cycle after that edge. An arrival in the same cycle as a pop of a full queue is accepted.
- R5: With queueing on, `trig_irq` is 1 when occupancy is at least the level chosen by control bits 7:6 (00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14). With queueing off, `trig_irq` equals `data_ready`.
- R6: In a control write with bit 0 clear, bits 7:6, 2 and 1 have no effect.
- R7: A control write with bits 0 and 1 set empties the receive queue. A control write with bits 0 and 2 set makes `tx_flush` 1 for one cycle and leaves stored entries intact. Neither bit has to be written back to 0.
- R8: A control write whose bit 0 differs from `fifo_on` sets `fifo_on` to that value, empties the receive queue and pulses `tx_flush`.
- R9: With queueing on and the queue non-empty, `timeout_irq` rises once 4 `char_tick` pulses have arrived since the last arrival or pop. Any arrival or pop clears it and restarts the count. It is never 1 while the queue is empty or queueing is off.
- R10: `err_any` is 1 exactly when at least one stored entry has its parity, framing or break flag set.
- R11: An arrival in the same cycle as a control write that empties the receive queue is discarded without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_byte | input | 8 | Control byte: bit0 on, bit1 clear rx, bit2 clear tx, bits 7:6 threshold |
| rx_valid | input | 1 | A received character is presented this cycle |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error flag of the character |
| rx_ferr | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Line break flag of the character |
| rd_pop | input | 1 | Remove the head entry |
| char_tick | input | 1 | One pulse per character time |
| head_data | output | 8 | Character of the oldest entry |
| head_perr | output | 1 | Parity flag of the oldest entry |
| head_ferr | output | 1 | Framing flag of the oldest entry |
| head_brk | output | 1 | Break flag of the oldest entry |
| data_ready | output | 1 | At least one entry stored |
| err_any | output | 1 | Some stored entry has an error flag |
| trig_irq | output | 1 | Occupancy at or above threshold |
| timeout_irq | output | 1 | Data left idle for 4 character times |
| overrun | output | 1 | A character was dropped at the last edge |
| fifo_on | output | 1 | Queueing enabled |
| tx_flush | output | 1 | One-cycle request to flush the transmit queue |

## Verification
The queue is first exercised with queueing off, where a second character must overrun the one-entry holder. It is then filled to all 16 entries with a mix of clean and flagged characters, which separates an ordering fault from a capacity fault or a flag-tracking fault. Draining one entry at a time while the threshold is switched among 14, 8 and 4 checks each threshold boundary from both sides. Tick sequences interrupted by pops and by arrivals show whether the timeout restarts, and simultaneous push/pop and push/clear cycles fix which of the two wins.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int RXQ_DATA_W = 8;

    // control byte bit positions
    localparam int CTL_ON_BIT    = 0;
    localparam int CTL_RXCLR_BIT = 1;
    localparam int CTL_TXCLR_BIT = 2;
    localparam int CTL_SEL_LO    = 6;

    typedef enum logic [1:0] {
        TRIG_ONE  = 2'b00,
        TRIG_FOUR = 2'b01,
        TRIG_EIGHT = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_sel_t;

    typedef struct packed {
        logic                  brk;
        logic                  ferr;
        logic                  perr;
        logic [RXQ_DATA_W-1:0] data;
    } rx_entry_t;

    function automatic int unsigned trig_level(input trig_sel_t sel);
        case (sel)
            TRIG_ONE:   return 1;
            TRIG_FOUR:  return 4;
            TRIG_EIGHT: return 8;
            default:    return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  rx_entry_t        wr_entry,
    input  logic             pop,
    input  logic             flush,
    output logic [CNT_W-1:0] occ,
    output rx_entry_t        head
);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] occ;
    } st_t;

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    st_t st_d, st_q;
    rx_entry_t mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push) st_d.wr_ptr = nxt(st_q.wr_ptr);
            if (pop)  st_d.rd_ptr = nxt(st_q.rd_ptr);
            case ({push, pop})
                2'b10:   st_d.occ = st_q.occ + 1'b1;
                2'b01:   st_d.occ = st_q.occ - 1'b1;
                default: st_d.occ = st_q.occ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[st_q.wr_ptr] <= wr_entry;
    end

    assign occ  = st_q.occ;
    assign head = mem_q[st_q.rd_ptr];

endmodule

// File: rtl/rxq_trig.sv
module rxq_trig
    import rxq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             fifo_on,
    input  trig_sel_t        sel,
    input  logic [CNT_W-1:0] occ,
    output logic             hit
);

    logic [CNT_W-1:0] level;

    always_comb begin
        level = CNT_W'(trig_level(sel));
        if (fifo_on) hit = (occ >= level);
        else         hit = (occ != '0);
    end

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int LIMIT = 4,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic restart,
    input  logic tick,
    output logic expired
);

    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tm_t;

    tm_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (!armed || restart)          tm_d.cnt = '0;
        else if (tick && tm_q.cnt < LIM) tm_d.cnt = tm_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign expired = (tm_q.cnt == LIM);

endmodule

// File: rtl/rx_queue_ctrl.sv
module rx_queue_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int TMO_CHARS = 4,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_we,
    input  logic [7:0]            ctl_byte,
    input  logic                  rx_valid,
    input  logic [RXQ_DATA_W-1:0] rx_data,
    input  logic                  rx_perr,
    input  logic                  rx_ferr,
    input  logic                  rx_brk,
    input  logic                  rd_pop,
    input  logic                  char_tick,
    output logic [RXQ_DATA_W-1:0] head_data,
    output logic                  head_perr,
    output logic                  head_ferr,
    output logic                  head_brk,
    output logic                  data_ready,
    output logic                  err_any,
    output logic                  trig_irq,
    output logic                  timeout_irq,
    output logic                  overrun,
    output logic                  fifo_on,
    output logic                  tx_flush
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    typedef struct packed {
        logic             on;
        trig_sel_t        sel;
        logic             txf;
        logic             ovr;
        logic [CNT_W-1:0] err_cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             en_change, apply, flush;
    logic             pop_ok, room, accept, drop;
    logic [CNT_W-1:0] occ, cap;
    rx_entry_t        new_entry, head;
    logic             new_err, head_err;

    assign new_entry = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};
    assign new_err   = rx_brk | rx_ferr | rx_perr;
    assign head_err  = head.brk | head.ferr | head.perr;

    always_comb begin
        en_change = ctl_we && (ctl_byte[CTL_ON_BIT] != ctl_q.on);
        apply     = ctl_we && ctl_byte[CTL_ON_BIT];
        flush     = en_change || (apply && ctl_byte[CTL_RXCLR_BIT]);
        cap       = ctl_q.on ? FULL_CNT : ONE_CNT;
        pop_ok    = rd_pop && (occ != '0) && !flush;
        room      = (occ < cap) || pop_ok;
        accept    = rx_valid && !flush && room;
        drop      = rx_valid && !flush && !room;

        ctl_d     = ctl_q;
        if (en_change) ctl_d.on = ctl_byte[CTL_ON_BIT];
        if (apply)     ctl_d.sel = trig_sel_t'(ctl_byte[CTL_SEL_LO+1:CTL_SEL_LO]);
        ctl_d.txf = en_change || (apply && ctl_byte[CTL_TXCLR_BIT]);
        ctl_d.ovr = drop;
        if (flush) begin
            ctl_d.err_cnt = '0;
        end else begin
            case ({accept && new_err, pop_ok && head_err})
                2'b10:   ctl_d.err_cnt = ctl_q.err_cnt + 1'b1;
                2'b01:   ctl_d.err_cnt = ctl_q.err_cnt - 1'b1;
                default: ctl_d.err_cnt = ctl_q.err_cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{on: 1'b0, sel: TRIG_ONE, txf: 1'b0, ovr: 1'b0, err_cnt: '0};
        else        ctl_q <= ctl_d;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .wr_entry (new_entry),
        .pop      (pop_ok),
        .flush    (flush),
        .occ      (occ),
        .head     (head)
    );

    rxq_trig #(.CNT_W(CNT_W)) u_trig (
        .fifo_on (ctl_q.on),
        .sel     (ctl_q.sel),
        .occ     (occ),
        .hit     (trig_irq)
    );

    rxq_timer #(.LIMIT(TMO_CHARS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (ctl_q.on && (occ != '0)),
        .restart (accept || pop_ok || flush),
        .tick    (char_tick),
        .expired (timeout_irq)
    );

    assign head_data  = head.data;
    assign head_perr  = head.perr;
    assign head_ferr  = head.ferr;
    assign head_brk   = head.brk;
    assign data_ready = (occ != '0);
    assign err_any    = (ctl_q.err_cnt != '0);
    assign overrun    = ctl_q.ovr;
    assign fifo_on    = ctl_q.on;
    assign tx_flush   = ctl_q.txf;

endmodule

module rxq_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_on,
    input logic [CNT_W-1:0] occ,
    input logic             rx_valid,
    input logic             rd_pop,
    input logic             ctl_we,
    input logic             overrun,
    input logic             timeout_irq,
    input logic             data_ready,
    input logic             err_any,
    input logic             trig_irq
);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    assert_single_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on |-> occ <= CNT_W'(1));

    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && rx_valid && occ == CNT_W'(DEPTH) && !rd_pop && !ctl_we)
        |=> (overrun && occ == CNT_W'(DEPTH)));

    assert_overrun_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_valid));

    assert_pop_shrinks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && occ != '0 && !rx_valid && !ctl_we)
        |=> occ == CNT_W'($past(occ) - 1'b1));

    assert_timeout_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_irq |-> (occ != '0 && fifo_on));

    assert_err_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |-> data_ready);

    assert_trig_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_irq |-> data_ready);

endmodule

bind rx_queue_ctrl rxq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_on     (fifo_on),
    .occ         (occ),
    .rx_valid    (rx_valid),
    .rd_pop      (rd_pop),
    .ctl_we      (ctl_we),
    .overrun     (overrun),
    .timeout_irq (timeout_irq),
    .data_ready  (data_ready),
    .err_any     (err_any),
    .trig_irq    (trig_irq)
);

// File: tb/rx_queue_ctrl_test.sv
`timescale 1ns/1ps
module rx_queue_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_byte = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic       rd_pop = 1'b0;
    logic       char_tick = 1'b0;
    logic [7:0] head_data;
    logic       head_perr, head_ferr, head_brk;
    logic       data_ready, err_any, trig_irq, timeout_irq, overrun, fifo_on, tx_flush;

    int total = 0;
    int bad = 0;

    logic [10:0] exp_q[$];
    bit          m_on = 1'b0;
    logic [1:0]  m_sel = 2'b00;

    always #4 clk = ~clk;

    rx_queue_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_byte(ctl_byte),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rd_pop(rd_pop),
        .char_tick(char_tick), .head_data(head_data), .head_perr(head_perr),
        .head_ferr(head_ferr), .head_brk(head_brk), .data_ready(data_ready),
        .err_any(err_any), .trig_irq(trig_irq), .timeout_irq(timeout_irq),
        .overrun(overrun), .fifo_on(fifo_on), .tx_flush(tx_flush)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int lvl(input logic [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic check_state();
        int e = 0;
        foreach (exp_q[i]) if (exp_q[i][10:8] != 3'b000) e = 1;
        chk("R2 data_ready", data_ready, exp_q.size() != 0);
        chk("R5 trig_irq", trig_irq,
            m_on ? (exp_q.size() >= lvl(m_sel)) : (exp_q.size() != 0));
        chk("R10 err_any", err_any, e);
    endtask

    // driver: presents one character and records what should be stored
    task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
        int cap = m_on ? 16 : 1;
        bit exp_ovr = (exp_q.size() >= cap);
        rx_valid = 1'b1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
        if (!exp_ovr) exp_q.push_back({b, f, p, d});
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R4 overrun", overrun, exp_ovr);
        check_state();
    endtask

    // monitor side: compares the head with the oldest expected item, then pops
    task automatic read_one();
        logic [10:0] want;
        chk("R2 ready before read", data_ready, 1);
        want = exp_q.pop_front();
        chk("R2 head entry", {head_brk, head_ferr, head_perr, head_data}, want);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        check_state();
    endtask

    task automatic push_pop(input logic [7:0] d);
        logic [10:0] want = exp_q.pop_front();
        chk("R4 head at push_pop", {head_brk, head_ferr, head_perr, head_data}, want);
        rx_valid = 1'b1; rx_data = d; rx_perr = 0; rx_ferr = 0; rx_brk = 0;
        rd_pop = 1'b1;
        exp_q.push_back({3'b000, d});
        @(negedge clk);
        rx_valid = 1'b0; rd_pop = 1'b0;
        chk("R4 no overrun with pop", overrun, 0);
        check_state();
    endtask

    task automatic ctl(input logic [7:0] b, input string req);
        bit chg = (b[0] != m_on);
        bit exp_tx = chg || (b[0] && b[2]);
        if (chg || (b[0] && b[1])) exp_q.delete();
        if (chg) m_on = b[0];
        if (b[0]) m_sel = b[7:6];
        ctl_we = 1'b1; ctl_byte = b;
        @(negedge clk);
        ctl_we = 1'b0;
        chk({req, " tx_flush"}, tx_flush, exp_tx);
        chk({req, " fifo_on"}, fifo_on, m_on);
        check_state();
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1'b1;
            @(negedge clk);
            char_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 data_ready", data_ready, 0);
        chk("R1 fifo_on", fifo_on, 0);
        chk("R1 trig_irq", trig_irq, 0);
        chk("R1 timeout_irq", timeout_irq, 0);
        chk("R1 err_any", err_any, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 tx_flush", tx_flush, 0);

        // R3: single holder while off, second char overruns
        push(8'h41, 0, 0, 0);
        push(8'h42, 0, 0, 0);
        // R6: clear and threshold ignored without bit 0
        ctl(8'hC6, "R6");
        read_one();
        push(8'h43, 0, 1, 0);
        // R8: enabling flushes
        ctl(8'h01, "R8");
        push(8'h50, 0, 0, 0);
        ctl(8'h41, "R5");
        push(8'h51, 1, 0, 0);
        for (int i = 2; i < 16; i++)
            push(8'h50 + 8'(i), (i == 9), (i == 12), (i == 15));
        chk("R3 full holds 16", data_ready, 1);
        push(8'hEE, 0, 0, 0);          // R4 overrun
        push_pop(8'h77);               // R4 accepted with pop
        ctl(8'hC1, "R5 sel14");
        for (int i = 0; i < 7; i++) read_one();
        ctl(8'h81, "R5 sel8");
        for (int i = 0; i < 4; i++) read_one();
        ctl(8'h41, "R5 sel4");
        while (exp_q.size() != 0) read_one();

        // R7: tx clear keeps data, rx clear empties
        push(8'h60, 0, 0, 1);
        push(8'h61, 0, 0, 0);
        ctl(8'h05, "R7 txclr");
        ctl(8'h03, "R7 rxclr");

        // R11: arrival during a clear is dropped
        rx_valid = 1'b1; rx_data = 8'h99;
        ctl(8'h03, "R11");
        rx_valid = 1'b0;
        chk("R11 no overrun", overrun, 0);
        chk("R11 empty", data_ready, 0);

        // R9 timeout
        push(8'h70, 0, 0, 0);
        push(8'h71, 0, 0, 0);
        tick(3);
        chk("R9 before limit", timeout_irq, 0);
        tick(1);
        chk("R9 at limit", timeout_irq, 1);
        read_one();
        chk("R9 read clears", timeout_irq, 0);
        tick(3);
        chk("R9 restart after read", timeout_irq, 0);
        tick(1);
        chk("R9 second expiry", timeout_irq, 1);
        push(8'h72, 0, 0, 0);
        chk("R9 arrival clears", timeout_irq, 0);
        tick(2);
        push(8'h73, 0, 0, 0);
        tick(3);
        chk("R9 arrival restarts", timeout_irq, 0);
        tick(1);
        chk("R9 expiry after arrival", timeout_irq, 1);
        while (exp_q.size() != 0) read_one();
        tick(5);
        chk("R9 empty never", timeout_irq, 0);

        // R8: disabling flushes; R9 no timeout while off
        push(8'h80, 0, 0, 0);
        ctl(8'h00, "R8 off");
        push(8'h81, 0, 0, 0);
        tick(6);
        chk("R9 off never", timeout_irq, 0);
        read_one();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule